// File: doc/BRIEF.md
# PCI Power-State Request Bridge

This block connects the PCI power-management register that an external host programs with the local processor that actually carries out power transitions. When the host writes a new power state, the block does not apply it. It records the request as a pending next state and raises an interrupt to the local core. The interrupt stays up for as long as the pending state and the committed current state differ. The host keeps reading the committed state until local software writes the new value into the current-state field. The hardware never steps into a low-power state by itself.

The block also turns wake-up activity into a PCI power-management event. There are five wake-up sources: magic packet, USB activity, GPIO transition, timer expiry and external interrupt. Each source has its own mask bit. While the device is out of D0, a rising edge on an enabled source latches a status bit. The active-low event output is driven while that status bit is set and both the host-side and the local event enables are set. Register accesses on both sides are single-cycle write strobes. Read data is combinational.

Top module: `pm_state_bridge`

## Requirements
- R1: After reset, next state and current state are D0 (00), all enables, the status bit and the wake mask are 0, `core_irq` is 0, `pme_n` is 1 and both read buses return 0 for the control registers.
- R2: A host write (`h_wr`) copies `h_wdata[1:0]` into the next-state field, readable at local address 0 bits [5:4] from the cycle after the write. The same write loads the host event enable from `h_wdata[4]`. The current state is not changed.
- R3: `core_irq` is 1 exactly while next state differs from current state. Power-state codes are D0=00, D1=01, D2=10, D3hot=11.
- R4: `h_rdata[1:0]` returns the current state, not the requested one. `h_rdata[4]` returns the host event enable and `h_rdata[7]` returns the event status.
- R5: The current state changes only on a local write to address 0, which loads it from `l_wdata[1:0]` and the local event enable from `l_wdata[7]`. With no such write it holds indefinitely, even with a request pending.
- R6: A local write to address 1 loads the wake mask from `l_wdata[4:0]`. The bits are: 0 magic packet, 1 USB activity, 2 GPIO transition, 3 timer expiry, 4 external interrupt. While current state is not D0, a 0-to-1 transition on an input whose mask bit is 1 sets the event status on the next clock edge.
- R7: A wake input has no effect on the event status while its mask bit is 0 or while current state is D0.
- R8: An input held at 1 sets the status only once, on its rising edge. After the status is cleared, the input must fall and rise again to set it.
- R9: `pme_n` is 0 exactly while event status, host event enable and local event enable are all 1. Clearing any of the three releases it.
- R10: A host write with `h_wdata[7]`=1 clears the event status. A host write with `h_wdata[7]`=0 leaves it unchanged. If a wake edge arrives in the same cycle as the clear, the status ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_wr | input | 1 | Host-side register write strobe |
| h_wdata | input | 8 | Host write data: [1:0] requested state, [4] event enable, [7] write 1 to clear status |
| h_rdata | output | 8 | Host read data: [1:0] current state, [4] event enable, [7] event status |
| l_wr | input | 1 | Local register write strobe |
| l_addr | input | 2 | Local register address: 0 control, 1 wake mask |
| l_wdata | input | 8 | Local write data |
| l_rdata | output | 8 | Local read data of the register at `l_addr` |
| wake_in | input | 5 | Wake-up source levels |
| core_irq | output | 1 | Interrupt to the local core: pending state differs from current |
| pme_n | output | 1 | Active-low power-management event |

## Verification
Every register-backed result is due on the first clock edge after the write or wake edge that causes it. `core_irq`, `pme_n` and both read buses are combinational from those registers, so they change in that same cycle. `l_rdata` follows `l_addr` with no delay. The bench changes its inputs shortly after each rising edge. A behavioural model advances on every rising edge, and every output is compared against the model at the following falling edge. Explicit checks at the same sampling point cover the reset values, ignored wake inputs, a held wake level, and the release of the event output.

// File: rtl/pm_bridge_pkg.sv
package pm_bridge_pkg;

  typedef enum logic [1:0] {
    PS_D0    = 2'b00,
    PS_D1    = 2'b01,
    PS_D2    = 2'b10,
    PS_D3HOT = 2'b11
  } pstate_e;

  // host register field positions
  localparam int unsigned H_PS_LSB  = 0;
  localparam int unsigned H_EN_BIT  = 4;
  localparam int unsigned H_STS_BIT = 7;

  // local register map
  localparam int unsigned L_ADDR_CTL  = 0;
  localparam int unsigned L_ADDR_MASK = 1;
  localparam int unsigned L_CUR_LSB   = 0;
  localparam int unsigned L_NXT_LSB   = 4;
  localparam int unsigned L_EN_BIT    = 7;

  function automatic logic pme_drive(input logic sts, input logic hen, input logic len);
    return sts & hen & len;
  endfunction

  function automatic logic awake_gate(input pstate_e cur);
    return cur != PS_D0;
  endfunction

endpackage

// File: rtl/pm_wake_gate.sv
module pm_wake_gate
  import pm_bridge_pkg::*;
#(
  parameter int unsigned WAKE_N = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WAKE_N-1:0] wake_in,
  input  logic [WAKE_N-1:0] wake_mask,
  input  pstate_e           cur_state,
  output logic              wake_set
);

  logic [WAKE_N-1:0] hit;

  generate
    for (genvar g = 0; g < WAKE_N; g++) begin : g_src
      logic prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= wake_in[g];
      end
      assign hit[g] = wake_in[g] & ~prev_q & wake_mask[g];
    end
  endgenerate

  assign wake_set = awake_gate(cur_state) & (|hit);

  // a set event must come from a source the mask admits
  assert_set_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wake_set |-> ((wake_in & wake_mask) != '0));

endmodule

// File: rtl/pm_host_regs.sv
module pm_host_regs
  import pm_bridge_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_wr,
  input  logic [DATA_W-1:0] h_wdata,
  input  pstate_e           cur_state,
  input  logic              wake_set,
  output pstate_e           next_req,
  output logic              host_pme_en,
  output logic              pme_status,
  output logic [DATA_W-1:0] h_rdata
);

  logic clr_req;
  assign clr_req = h_wr & h_wdata[H_STS_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_req    <= PS_D0;
      host_pme_en <= 1'b0;
      pme_status  <= 1'b0;
    end else begin
      if (h_wr) begin
        next_req    <= pstate_e'(h_wdata[H_PS_LSB +: 2]);
        host_pme_en <= h_wdata[H_EN_BIT];
      end
      if (wake_set)     pme_status <= 1'b1;
      else if (clr_req) pme_status <= 1'b0;
    end
  end

  always_comb begin
    h_rdata = '0;
    h_rdata[H_PS_LSB +: 2] = cur_state;
    h_rdata[H_EN_BIT]      = host_pme_en;
    h_rdata[H_STS_BIT]     = pme_status;
  end

  assert_next_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    h_wr |=> (next_req == $past(h_wdata[H_PS_LSB +: 2])));

  assert_w1c_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !wake_set) |=> !pme_status);

  assert_no_wake_in_d0_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pme_status) |-> $past(cur_state != PS_D0));

  assert_wake_latches_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wake_set |=> pme_status);

endmodule

// File: rtl/pm_local_regs.sv
module pm_local_regs
  import pm_bridge_pkg::*;
#(
  parameter int unsigned WAKE_N = 5,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_wr,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  input  pstate_e           next_req,
  output pstate_e           cur_state,
  output logic              local_pme_en,
  output logic [WAKE_N-1:0] wake_mask,
  output logic [DATA_W-1:0] l_rdata,
  output logic              state_differs
);

  logic wr_ctl, wr_mask;
  assign wr_ctl  = l_wr && (l_addr == ADDR_W'(L_ADDR_CTL));
  assign wr_mask = l_wr && (l_addr == ADDR_W'(L_ADDR_MASK));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_state    <= PS_D0;
      local_pme_en <= 1'b0;
      wake_mask    <= '0;
    end else begin
      if (wr_ctl) begin
        cur_state    <= pstate_e'(l_wdata[L_CUR_LSB +: 2]);
        local_pme_en <= l_wdata[L_EN_BIT];
      end
      if (wr_mask) wake_mask <= l_wdata[WAKE_N-1:0];
    end
  end

  assign state_differs = (next_req != cur_state);

  always_comb begin
    l_rdata = '0;
    if (l_addr == ADDR_W'(L_ADDR_CTL)) begin
      l_rdata[L_CUR_LSB +: 2] = cur_state;
      l_rdata[L_NXT_LSB +: 2] = next_req;
      l_rdata[L_EN_BIT]       = local_pme_en;
    end else if (l_addr == ADDR_W'(L_ADDR_MASK)) begin
      l_rdata[WAKE_N-1:0] = wake_mask;
    end
  end

  assert_cur_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctl |=> $stable(cur_state));

  assert_irq_has_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_differs) |-> ($past(wr_ctl) || !$stable(next_req)));

endmodule

// File: rtl/pm_state_bridge.sv
module pm_state_bridge
  import pm_bridge_pkg::*;
#(
  parameter int unsigned WAKE_N = 5,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_wr,
  input  logic [DATA_W-1:0] h_wdata,
  output logic [DATA_W-1:0] h_rdata,
  input  logic              l_wr,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  input  logic [WAKE_N-1:0] wake_in,
  output logic              core_irq,
  output logic              pme_n
);

  pstate_e           next_req, cur_state;
  logic              host_pme_en, local_pme_en, pme_status;
  logic              wake_set, state_differs;
  logic [WAKE_N-1:0] wake_mask;

  pm_host_regs #(.DATA_W(DATA_W)) u_host (
    .clk(clk), .rst_n(rst_n), .h_wr(h_wr), .h_wdata(h_wdata),
    .cur_state(cur_state), .wake_set(wake_set), .next_req(next_req),
    .host_pme_en(host_pme_en), .pme_status(pme_status), .h_rdata(h_rdata)
  );

  pm_local_regs #(.WAKE_N(WAKE_N), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_local (
    .clk(clk), .rst_n(rst_n), .l_wr(l_wr), .l_addr(l_addr), .l_wdata(l_wdata),
    .next_req(next_req), .cur_state(cur_state), .local_pme_en(local_pme_en),
    .wake_mask(wake_mask), .l_rdata(l_rdata), .state_differs(state_differs)
  );

  pm_wake_gate #(.WAKE_N(WAKE_N)) u_wake (
    .clk(clk), .rst_n(rst_n), .wake_in(wake_in), .wake_mask(wake_mask),
    .cur_state(cur_state), .wake_set(wake_set)
  );

  assign core_irq = state_differs;
  assign pme_n    = ~pme_drive(pme_status, host_pme_en, local_pme_en);

  // the event output only falls as a result of a register write or a wake edge
  assert_pme_has_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pme_n) |-> $past(wake_set || h_wr || l_wr));

  // a pending request alone never commits a state
  assert_irq_stays_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (core_irq && !l_wr && !h_wr) |=> core_irq);

endmodule

// File: tb/test_pm_state_bridge.sv
`timescale 1ns/1ps
module test_pm_state_bridge;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       h_wr = 1'b0;
  logic [7:0] h_wdata = '0;
  logic [7:0] h_rdata;
  logic       l_wr = 1'b0;
  logic [1:0] l_addr = '0;
  logic [7:0] l_wdata = '0;
  logic [7:0] l_rdata;
  logic [4:0] wake_in = '0;
  logic       core_irq, pme_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pm_state_bridge i_pm_state_bridge (
    .clk(clk), .rst_n(rst_n), .h_wr(h_wr), .h_wdata(h_wdata), .h_rdata(h_rdata),
    .l_wr(l_wr), .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
    .wake_in(wake_in), .core_irq(core_irq), .pme_n(pme_n)
  );

  // behavioural reference
  int m_next, m_cur, m_mask, m_prev;
  bit m_hen, m_len, m_sts;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_next = 0; m_cur = 0; m_mask = 0; m_prev = 0;
      m_hen = 0; m_len = 0; m_sts = 0;
    end else begin
      bit wake_evt;
      wake_evt = 0;
      for (int i = 0; i < 5; i++)
        if (wake_in[i] && !m_prev[i] && m_mask[i] && m_cur != 0) wake_evt = 1;
      if (h_wr) begin
        m_next = h_wdata[1:0];
        m_hen  = h_wdata[4];
        if (h_wdata[7]) m_sts = 0;
      end
      if (wake_evt) m_sts = 1;
      if (l_wr && l_addr == 0) begin
        m_cur = l_wdata[1:0];
        m_len = l_wdata[7];
      end
      if (l_wr && l_addr == 1) m_mask = l_wdata[4:0];
      m_prev = wake_in;
    end
  end

  task automatic chk(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int exp_l;
      chk(core_irq, (m_next != m_cur), "R3 core_irq");
      chk(pme_n, !(m_sts && m_hen && m_len), "R9 pme_n");
      chk(h_rdata[1:0], m_cur, "R4 host state");
      chk(h_rdata[4], m_hen, "R2 host enable");
      chk(h_rdata[7], m_sts, "R10 status");
      if (l_addr == 0)      exp_l = (m_len << 7) | (m_next << 4) | m_cur;
      else if (l_addr == 1) exp_l = m_mask;
      else                  exp_l = 0;
      chk(l_rdata, exp_l, "R5 local read");
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic host_write(input logic [7:0] d);
    h_wr = 1'b1; h_wdata = d;
    step(1);
    h_wr = 1'b0;
  endtask

  task automatic local_write(input logic [1:0] a, input logic [7:0] d);
    l_wr = 1'b1; l_addr = a; l_wdata = d;
    step(1);
    l_wr = 1'b0;
  endtask

  task automatic pulse(input int idx);
    wake_in[idx] = 1'b1;
    step(1);
    wake_in[idx] = 1'b0;
    step(1);
  endtask

  task automatic at_sample;
    @(negedge clk); #0.1;
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    at_sample;
    chk(core_irq, 0, "R1 irq");
    chk(pme_n, 1, "R1 pme_n");
    chk(h_rdata, 0, "R1 host read");
    chk(l_rdata, 0, "R1 local read");
    step(1);

    local_write(1, 8'h15);        // mask magic packet, GPIO, ext int
    local_write(0, 8'h80);        // local enable, state D0
    host_write(8'h10);            // host enable, request D0
    host_write(8'h13);            // request D3hot
    at_sample;
    chk(core_irq, 1, "R3 request raises irq");
    chk(h_rdata[1:0], 0, "R4 host still reads D0");
    chk(l_rdata[5:4], 3, "R2 next-state D3hot");
    step(1);
    step(20);
    at_sample;
    chk(h_rdata[1:0], 0, "R5 no autonomous transition");
    step(1);

    pulse(0);                     // current D0: ignored
    at_sample;
    chk(h_rdata[7], 0, "R7 wake ignored in D0");
    step(1);

    local_write(0, 8'h83);        // commit D3hot
    at_sample;
    chk(core_irq, 0, "R3 irq drops after commit");
    chk(h_rdata[1:0], 3, "R4 host reads D3hot");
    step(1);

    pulse(1);                     // masked source
    at_sample;
    chk(pme_n, 1, "R7 masked source ignored");
    step(1);

    pulse(2);
    at_sample;
    chk(pme_n, 0, "R6 GPIO edge raises event");
    step(1);
    host_write(8'h13);            // status bit written 0
    at_sample;
    chk(h_rdata[7], 1, "R10 write of 0 keeps status");
    step(1);
    host_write(8'h93);
    at_sample;
    chk(pme_n, 1, "R10 W1C releases event");
    step(1);

    wake_in[4] = 1'b1;            // held level
    step(2);
    host_write(8'h93);
    step(5);
    at_sample;
    chk(h_rdata[7], 0, "R8 held level sets once");
    step(1);
    wake_in[4] = 1'b0;
    step(1);

    // clear and new edge in the same cycle: set wins
    h_wr = 1'b1; h_wdata = 8'h93; wake_in[0] = 1'b1;
    step(1);
    h_wr = 1'b0; wake_in[0] = 1'b0;
    at_sample;
    chk(h_rdata[7], 1, "R10 set wins over clear");
    step(1);

    local_write(0, 8'h03);        // drop local enable
    at_sample;
    chk(pme_n, 1, "R9 local enable gates event");
    step(1);
    local_write(0, 8'h83);
    host_write(8'h03);            // drop host enable
    at_sample;
    chk(pme_n, 1, "R9 host enable gates event");
    step(1);

    host_write(8'h91);            // request D1, clear status
    local_write(0, 8'h81);
    host_write(8'h12);            // request D2
    local_write(0, 8'h82);
    pulse(4);
    host_write(8'h10);            // back to D0
    at_sample;
    chk(core_irq, 1, "R3 request D0 pending");
    step(1);
    local_write(0, 8'h80);
    local_write(2, 8'hff);        // unmapped address
    l_addr = 2'd3;
    step(3);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule